// File: doc/BRIEF.md
# Exception Request Arbiter and Vector Generator

This block sits beside the issue and completion logic of a 32-bit RISC core. It gathers every raw exception and interrupt request in the core. Each request has its own enable rule, which the block applies using the machine-state enable bits supplied as inputs. The block then picks a single winner by fixed priority. One clock later it presents the winner's vector address together with a one-cycle take strobe. The core uses that strobe to flush and redirect fetch. Saving the return state and the flush itself happen outside this block.

Asynchronous sources are levels. They stay visible until the core takes them and the source drops. The decrementer is different: the block watches its most significant bit and latches a rise of that bit into a sticky pending flag. A machine-check request that arrives while machine checks are disabled does not vector. Instead, the block raises a checkstop indication.

Top module: `exc_vector_sel`

## Requirements
- R1: While and directly after the synchronous reset `rst`, `exc_take_out`, `checkstop_out` and `exc_vector_out` are all 0. The decrementer pending flag is cleared. The stored decrementer MSB is treated as 1, so a decrementer already negative at reset is not a rise.
- R2: The synchronous sources map to these offsets. `sync_fault_in[0]` instruction storage gives 0x400. `[1]` program gives 0x700. `[2]` FP unavailable gives 0x800. `[3]` system call gives 0xC00. `[4]` alignment gives 0x600. `[5]` data storage gives 0x300. `iabr_hit_in` gives 0x1300. None of these has an enable bit.
- R3: Any of `por_in`, `hard_reset_in` or `soft_reset_in` requests offset 0x100. This request outranks every other source.
- R4: Any of the bus-error, machine-check pin or address, data or L2 double-bit-error inputs raises a machine check. With `msr_me_in`=1 it vectors to 0x200. With `msr_me_in`=0 and no reset request, `checkstop_out` is 1 in the next cycle and no exception is taken that cycle.
- R5: External (0x500), system-management (0x1400) and thermal (0x1700) requests are taken only while `msr_ee_in`=1.
- R6: A 0-to-1 change of `dec_value_in[31]` sets a pending request for offset 0x900. The request is taken only while `msr_ee_in`=1. It persists while `msr_ee_in`=0 and clears when taken. Holding bit 31 at 1 raises no further request.
- R7: Trace (0xD00) is raised when `instr_done_in`=1 and either `msr_se_in`=1, or `branch_done_in`=1 with `msr_be_in`=1. It is not raised when `instr_is_sync_in`=1.
- R8: The performance-monitor request (0xF00) needs both `pmon_limit_in`=1 and `pmon_int_en_in`=1. It does not depend on `msr_ee_in`.
- R9: Priority runs from highest to lowest as follows. Reset, then machine check, then instruction breakpoint. Next come instruction storage, program, FP unavailable, system call, alignment and data storage. After those come external, system management, thermal, performance monitor, decrementer and trace.
- R10: The take strobe and vector appear one clock after the request is presented. The strobe is never high in two consecutive cycles. When the strobe is low, the vector is 0.
- R11: The vector is the 20-bit offset ORed with 0xFFF00000 when `msr_ip_in` was 1 in the request cycle. Otherwise the upper bits are 0.
- R12: Offset 0xE00 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| por_in | input | 1 | Power-on reset request |
| hard_reset_in | input | 1 | Hard reset pin request |
| soft_reset_in | input | 1 | Soft reset pin request |
| bus_err_in | input | 1 | Transfer error acknowledged during a data transaction |
| mcheck_in | input | 1 | Machine-check interrupt pin |
| addr_dbe_in | input | 1 | Address double-bit error |
| data_dbe_in | input | 1 | Data double-bit error |
| l2_dbe_in | input | 1 | L2 double-bit error |
| ext_irq_in | input | 1 | External interrupt level |
| smgmt_irq_in | input | 1 | System-management interrupt level |
| thermal_hot_in | input | 1 | Junction temperature beyond threshold |
| pmon_limit_in | input | 1 | Performance counter reached its limit |
| pmon_int_en_in | input | 1 | Performance-monitor interrupt enable |
| dec_value_in | input | 32 | Decrementer value; bit 31 is watched |
| instr_done_in | input | 1 | An instruction completed this cycle |
| instr_is_sync_in | input | 1 | The completing instruction is an instruction-sync |
| branch_done_in | input | 1 | The completing instruction is a branch |
| iabr_hit_in | input | 1 | Instruction address breakpoint match |
| sync_fault_in | input | 6 | Synchronous instruction faults, bit mapping per R2 |
| msr_ee_in | input | 1 | External-interrupt enable |
| msr_me_in | input | 1 | Machine-check enable |
| msr_se_in | input | 1 | Single-step trace enable |
| msr_be_in | input | 1 | Branch trace enable |
| msr_ip_in | input | 1 | High vector base select |
| exc_take_out | output | 1 | One-cycle strobe: an exception is taken |
| exc_vector_out | output | 32 | Vector address of the taken exception |
| checkstop_out | output | 1 | Machine check arrived while disabled |

## Verification
Some functions of the block can land in the same cycle. The main case is a decrementer rise arriving together with an enabled external request. The external request wins that cycle, and the decrementer rise must survive as a pending flag through the following holdoff cycle. The bench sets up exactly this coincidence and then checks the outputs cycle by cycle: 0x500 first, a quiet cycle, then 0x900. The table also pairs sources in the same cycle to confirm the ranking, for example a reset pin together with a disabled machine check, or a trace step together with a performance-monitor request.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int NSRC   = 15;
    localparam int SYNC_W = 6;
    localparam int OFS_W  = 20;
    localparam int VEC_W  = 32;
    localparam logic [VEC_W-1:0] HIGH_BASE = 32'hFFF0_0000;

    // Enum value equals priority rank: lower value wins.
    typedef enum logic [3:0] {
        SRC_RESET = 4'd0,
        SRC_MCHK  = 4'd1,
        SRC_IABR  = 4'd2,
        SRC_ISI   = 4'd3,
        SRC_PROG  = 4'd4,
        SRC_FPU   = 4'd5,
        SRC_SC    = 4'd6,
        SRC_ALIGN = 4'd7,
        SRC_DSI   = 4'd8,
        SRC_EXT   = 4'd9,
        SRC_SMI   = 4'd10,
        SRC_THERM = 4'd11,
        SRC_PMON  = 4'd12,
        SRC_DEC   = 4'd13,
        SRC_TRACE = 4'd14,
        SRC_NONE  = 4'd15
    } src_e;

    typedef struct packed {
        logic ee;
        logic me;
        logic se;
        logic be;
        logic ip;
    } msr_bits_t;

    typedef struct packed {
        logic valid;
        src_e src;
    } pick_t;

    function automatic logic [OFS_W-1:0] src_offset(src_e s);
        case (s)
            SRC_RESET: return 20'h00100;
            SRC_MCHK:  return 20'h00200;
            SRC_DSI:   return 20'h00300;
            SRC_ISI:   return 20'h00400;
            SRC_EXT:   return 20'h00500;
            SRC_ALIGN: return 20'h00600;
            SRC_PROG:  return 20'h00700;
            SRC_FPU:   return 20'h00800;
            SRC_DEC:   return 20'h00900;
            SRC_SC:    return 20'h00C00;
            SRC_TRACE: return 20'h00D00;
            SRC_PMON:  return 20'h00F00;
            SRC_IABR:  return 20'h01300;
            SRC_SMI:   return 20'h01400;
            SRC_THERM: return 20'h01700;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/exc_dec_watch.sv
module exc_dec_watch #(
    parameter int DEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEC_W-1:0] dec_value,
    input  logic             dec_taken,
    output logic             dec_req
);
    localparam int MSB = DEC_W - 1;

    logic msb_prev_q;
    logic pend_q;
    logic rise;

    assign rise    = ~msb_prev_q & dec_value[MSB];
    assign dec_req = pend_q | rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            msb_prev_q <= 1'b1;
            pend_q     <= 1'b0;
        end else begin
            msb_prev_q <= dec_value[MSB];
            pend_q     <= (pend_q | rise) & ~dec_taken;
        end
    end
endmodule

// File: rtl/exc_req_gate.sv
module exc_req_gate
    import exc_pkg::*;
(
    input  logic              por,
    input  logic              hard_rst,
    input  logic              soft_rst,
    input  logic              bus_err,
    input  logic              mcheck,
    input  logic              addr_dbe,
    input  logic              data_dbe,
    input  logic              l2_dbe,
    input  logic              ext_irq,
    input  logic              smgmt_irq,
    input  logic              thermal_hot,
    input  logic              pmon_limit,
    input  logic              pmon_int_en,
    input  logic              dec_req,
    input  logic              instr_done,
    input  logic              instr_is_sync,
    input  logic              branch_done,
    input  logic              iabr_hit,
    input  logic [SYNC_W-1:0] sync_fault,
    input  msr_bits_t         msr,
    output logic [NSRC-1:0]   req,
    output logic              mc_blocked
);
    logic mc_raw;
    logic trace_ev;

    assign mc_raw   = bus_err | mcheck | addr_dbe | data_dbe | l2_dbe;
    assign trace_ev = instr_done & ~instr_is_sync &
                      (msr.se | (branch_done & msr.be));

    always_comb begin
        req = '0;
        req[int'(SRC_RESET)] = por | hard_rst | soft_rst;
        req[int'(SRC_MCHK)]  = mc_raw & msr.me;
        req[int'(SRC_IABR)]  = iabr_hit;
        for (int i = 0; i < SYNC_W; i++) begin
            req[int'(SRC_ISI) + i] = sync_fault[i];
        end
        req[int'(SRC_EXT)]   = ext_irq & msr.ee;
        req[int'(SRC_SMI)]   = smgmt_irq & msr.ee;
        req[int'(SRC_THERM)] = thermal_hot & msr.ee;
        req[int'(SRC_PMON)]  = pmon_limit & pmon_int_en;
        req[int'(SRC_DEC)]   = dec_req & msr.ee;
        req[int'(SRC_TRACE)] = trace_ev;
    end

    assign mc_blocked = mc_raw & ~msr.me;
endmodule

// File: rtl/exc_pick.sv
module exc_pick
    import exc_pkg::*;
(
    input  logic [NSRC-1:0] req,
    output pick_t           win
);
    always_comb begin
        win.valid = 1'b0;
        win.src   = SRC_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                win.valid = 1'b1;
                win.src   = src_e'(i[3:0]);
            end
        end
    end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_pkg::*;
#(
    parameter int DEC_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 por_in,
    input  logic                 hard_reset_in,
    input  logic                 soft_reset_in,
    input  logic                 bus_err_in,
    input  logic                 mcheck_in,
    input  logic                 addr_dbe_in,
    input  logic                 data_dbe_in,
    input  logic                 l2_dbe_in,
    input  logic                 ext_irq_in,
    input  logic                 smgmt_irq_in,
    input  logic                 thermal_hot_in,
    input  logic                 pmon_limit_in,
    input  logic                 pmon_int_en_in,
    input  logic [DEC_W-1:0]     dec_value_in,
    input  logic                 instr_done_in,
    input  logic                 instr_is_sync_in,
    input  logic                 branch_done_in,
    input  logic                 iabr_hit_in,
    input  logic [SYNC_W-1:0]    sync_fault_in,
    input  logic                 msr_ee_in,
    input  logic                 msr_me_in,
    input  logic                 msr_se_in,
    input  logic                 msr_be_in,
    input  logic                 msr_ip_in,
    output logic                 exc_take_out,
    output logic [VEC_W-1:0]     exc_vector_out,
    output logic                 checkstop_out
);
    msr_bits_t        msr;
    logic [NSRC-1:0]  req;
    logic             mc_blocked;
    logic             dec_req;
    pick_t            win;
    logic             halt;
    logic             fire;
    logic             dec_taken;
    logic [VEC_W-1:0] vec_next;

    logic             take_q;
    logic             stop_q;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
        msr.ee = msr_ee_in;
        msr.me = msr_me_in;
        msr.se = msr_se_in;
        msr.be = msr_be_in;
        msr.ip = msr_ip_in;
    end

    exc_dec_watch #(.DEC_W(DEC_W)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .dec_value (dec_value_in),
        .dec_taken (dec_taken),
        .dec_req   (dec_req)
    );

    exc_req_gate u_gate (
        .por           (por_in),
        .hard_rst      (hard_reset_in),
        .soft_rst      (soft_reset_in),
        .bus_err       (bus_err_in),
        .mcheck        (mcheck_in),
        .addr_dbe      (addr_dbe_in),
        .data_dbe      (data_dbe_in),
        .l2_dbe        (l2_dbe_in),
        .ext_irq       (ext_irq_in),
        .smgmt_irq     (smgmt_irq_in),
        .thermal_hot   (thermal_hot_in),
        .pmon_limit    (pmon_limit_in),
        .pmon_int_en   (pmon_int_en_in),
        .dec_req       (dec_req),
        .instr_done    (instr_done_in),
        .instr_is_sync (instr_is_sync_in),
        .branch_done   (branch_done_in),
        .iabr_hit      (iabr_hit_in),
        .sync_fault    (sync_fault_in),
        .msr           (msr),
        .req           (req),
        .mc_blocked    (mc_blocked)
    );

    exc_pick u_pick (
        .req (req),
        .win (win)
    );

    // A disabled machine check stops vectoring unless a reset is requested.
    assign halt      = mc_blocked & ~req[int'(SRC_RESET)];
    // The cycle after a take is a holdoff cycle while the core redirects.
    assign fire      = win.valid & ~take_q & ~halt;
    assign dec_taken = fire & (win.src == SRC_DEC);
    assign vec_next  = {{(VEC_W-OFS_W){1'b0}}, src_offset(win.src)} |
                       (msr.ip ? HIGH_BASE : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q <= 1'b0;
            stop_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= fire;
            stop_q <= halt;
            vec_q  <= fire ? vec_next : '0;
        end
    end

    assign exc_take_out   = take_q;
    assign checkstop_out  = stop_q;
    assign exc_vector_out = vec_q;
endmodule

// File: rtl/exc_vector_sel_chk.sv
module exc_vector_sel_chk (
    input logic        clk,
    input logic        rst,
    input logic        por_in,
    input logic        hard_reset_in,
    input logic        soft_reset_in,
    input logic        msr_ee_in,
    input logic        msr_me_in,
    input logic        msr_ip_in,
    input logic        exc_take_out,
    input logic [31:0] exc_vector_out,
    input logic        checkstop_out
);
    p_take_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        exc_take_out |=> !exc_take_out);

    p_no_e00_r12: assert property (@(posedge clk) disable iff (rst)
        exc_take_out |-> exc_vector_out[19:0] != 20'hE00);

    p_stop_no_take_r4: assert property (@(posedge clk) disable iff (rst)
        checkstop_out |-> !exc_take_out);

    p_mc_enabled_r4: assert property (@(posedge clk) disable iff (rst)
        (exc_take_out && exc_vector_out[19:0] == 20'h00200) |-> $past(msr_me_in));

    p_ee_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (exc_take_out && (exc_vector_out[19:0] == 20'h00500 ||
                          exc_vector_out[19:0] == 20'h01400 ||
                          exc_vector_out[19:0] == 20'h01700)) |-> $past(msr_ee_in));

    p_dec_ee_r6: assert property (@(posedge clk) disable iff (rst)
        (exc_take_out && exc_vector_out[19:0] == 20'h00900) |-> $past(msr_ee_in));

    p_base_r11: assert property (@(posedge clk) disable iff (rst)
        exc_take_out |-> exc_vector_out[31:20] == ($past(msr_ip_in) ? 12'hFFF : 12'h000));

    p_reset_first_r3: assert property (@(posedge clk) disable iff (rst)
        (exc_take_out && $past(por_in | hard_reset_in | soft_reset_in))
            |-> exc_vector_out[19:0] == 20'h00100);
endmodule

bind exc_vector_sel exc_vector_sel_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .por_in         (por_in),
    .hard_reset_in  (hard_reset_in),
    .soft_reset_in  (soft_reset_in),
    .msr_ee_in      (msr_ee_in),
    .msr_me_in      (msr_me_in),
    .msr_ip_in      (msr_ip_in),
    .exc_take_out   (exc_take_out),
    .exc_vector_out (exc_vector_out),
    .checkstop_out  (checkstop_out)
);

// File: tb/exc_vector_sel_bench.sv
`timescale 1ns/1ps
module exc_vector_sel_bench;

    localparam logic [27:0] S_POR   = 28'h0000001;
    localparam logic [27:0] S_HARD  = 28'h0000002;
    localparam logic [27:0] S_SOFT  = 28'h0000004;
    localparam logic [27:0] S_BERR  = 28'h0000008;
    localparam logic [27:0] S_MCP   = 28'h0000010;
    localparam logic [27:0] S_ADBE  = 28'h0000020;
    localparam logic [27:0] S_DDBE  = 28'h0000040;
    localparam logic [27:0] S_L2    = 28'h0000080;
    localparam logic [27:0] S_EXT   = 28'h0000100;
    localparam logic [27:0] S_SMI   = 28'h0000200;
    localparam logic [27:0] S_THERM = 28'h0000400;
    localparam logic [27:0] S_PLIM  = 28'h0000800;
    localparam logic [27:0] S_PEN   = 28'h0001000;
    localparam logic [27:0] S_DONE  = 28'h0002000;
    localparam logic [27:0] S_SYNC  = 28'h0004000;
    localparam logic [27:0] S_BR    = 28'h0008000;
    localparam logic [27:0] S_IABR  = 28'h0010000;
    localparam logic [27:0] S_ISI   = 28'h0020000;
    localparam logic [27:0] S_PROG  = 28'h0040000;
    localparam logic [27:0] S_FPU   = 28'h0080000;
    localparam logic [27:0] S_SC    = 28'h0100000;
    localparam logic [27:0] S_ALN   = 28'h0200000;
    localparam logic [27:0] S_DSI   = 28'h0400000;
    localparam logic [27:0] S_EE    = 28'h0800000;
    localparam logic [27:0] S_ME    = 28'h1000000;
    localparam logic [27:0] S_SE    = 28'h2000000;
    localparam logic [27:0] S_BE    = 28'h4000000;
    localparam logic [27:0] S_IP    = 28'h8000000;

    typedef struct packed {
        logic [27:0] stim;
        logic [3:0]  rq;
        logic        take;
        logic        cs;
        logic [31:0] vec;
    } row_t;

    localparam int NROWS = 45;
    localparam row_t TBL [NROWS] = '{
        '{S_POR,                       4'd3,  1'b1, 1'b0, 32'h100},   // R3
        '{S_HARD,                      4'd3,  1'b1, 1'b0, 32'h100},   // R3
        '{S_SOFT | S_EXT | S_EE,       4'd3,  1'b1, 1'b0, 32'h100},   // R3
        '{S_BERR | S_ME,               4'd4,  1'b1, 1'b0, 32'h200},   // R4
        '{S_MCP | S_ME,                4'd4,  1'b1, 1'b0, 32'h200},   // R4
        '{S_ADBE | S_ME,               4'd4,  1'b1, 1'b0, 32'h200},   // R4
        '{S_DDBE | S_ME,               4'd4,  1'b1, 1'b0, 32'h200},   // R4
        '{S_L2 | S_ME,                 4'd4,  1'b1, 1'b0, 32'h200},   // R4
        '{S_L2,                        4'd4,  1'b0, 1'b1, 32'h0},     // R4 checkstop
        '{S_MCP | S_EXT | S_EE,        4'd4,  1'b0, 1'b1, 32'h0},     // R4 checkstop blocks all
        '{S_ISI,                       4'd2,  1'b1, 1'b0, 32'h400},   // R2
        '{S_PROG,                      4'd2,  1'b1, 1'b0, 32'h700},   // R2
        '{S_FPU,                       4'd2,  1'b1, 1'b0, 32'h800},   // R2
        '{S_SC,                        4'd2,  1'b1, 1'b0, 32'hC00},   // R2
        '{S_ALN,                       4'd2,  1'b1, 1'b0, 32'h600},   // R2
        '{S_DSI,                       4'd2,  1'b1, 1'b0, 32'h300},   // R2
        '{S_IABR,                      4'd2,  1'b1, 1'b0, 32'h1300},  // R2
        '{S_IABR | S_ISI,              4'd9,  1'b1, 1'b0, 32'h1300},  // R9
        '{S_ISI | S_PROG | S_DSI,      4'd9,  1'b1, 1'b0, 32'h400},   // R9
        '{S_ALN | S_DSI,               4'd9,  1'b1, 1'b0, 32'h600},   // R9
        '{S_PROG | S_SC,               4'd9,  1'b1, 1'b0, 32'h700},   // R9
        '{S_EXT,                       4'd5,  1'b0, 1'b0, 32'h0},     // R5
        '{S_EXT | S_EE,                4'd5,  1'b1, 1'b0, 32'h500},   // R5
        '{S_SMI | S_EE,                4'd5,  1'b1, 1'b0, 32'h1400},  // R5
        '{S_SMI,                       4'd5,  1'b0, 1'b0, 32'h0},     // R5
        '{S_THERM | S_EE,              4'd5,  1'b1, 1'b0, 32'h1700},  // R5
        '{S_THERM,                     4'd5,  1'b0, 1'b0, 32'h0},     // R5
        '{S_EXT | S_SMI | S_THERM | S_EE, 4'd9, 1'b1, 1'b0, 32'h500}, // R9
        '{S_SMI | S_THERM | S_EE,      4'd9,  1'b1, 1'b0, 32'h1400},  // R9
        '{S_PLIM | S_PEN,              4'd8,  1'b1, 1'b0, 32'hF00},   // R8
        '{S_PLIM,                      4'd8,  1'b0, 1'b0, 32'h0},     // R8
        '{S_PEN,                       4'd8,  1'b0, 1'b0, 32'h0},     // R8
        '{S_PLIM | S_PEN | S_THERM | S_EE, 4'd9, 1'b1, 1'b0, 32'h1700}, // R9
        '{S_DONE | S_SE,               4'd7,  1'b1, 1'b0, 32'hD00},   // R7
        '{S_DONE | S_SYNC | S_SE,      4'd7,  1'b0, 1'b0, 32'h0},     // R7
        '{S_DONE | S_BR | S_BE,        4'd7,  1'b1, 1'b0, 32'hD00},   // R7
        '{S_DONE | S_BE,               4'd7,  1'b0, 1'b0, 32'h0},     // R7
        '{S_BR | S_BE,                 4'd7,  1'b0, 1'b0, 32'h0},     // R7
        '{S_DONE | S_BR | S_BE | S_SYNC, 4'd7, 1'b0, 1'b0, 32'h0},    // R7
        '{S_DONE | S_SE | S_PLIM | S_PEN, 4'd9, 1'b1, 1'b0, 32'hF00}, // R9
        '{S_DSI | S_EXT | S_EE,        4'd9,  1'b1, 1'b0, 32'h300},   // R9
        '{S_MCP | S_ME | S_IABR,       4'd9,  1'b1, 1'b0, 32'h200},   // R9
        '{S_EXT | S_EE | S_IP,         4'd11, 1'b1, 1'b0, 32'hFFF00500}, // R11
        '{S_POR | S_IP,                4'd11, 1'b1, 1'b0, 32'hFFF00100}, // R11
        '{S_IABR | S_IP,               4'd11, 1'b1, 1'b0, 32'hFFF01300}  // R11
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [27:0] s;
    logic [31:0] dec;
    logic        take;
    logic        cs;
    logic [31:0] vec;
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    exc_vector_sel u_exc_vector_sel (
        .clk              (clk),
        .rst              (rst),
        .por_in           (s[0]),
        .hard_reset_in    (s[1]),
        .soft_reset_in    (s[2]),
        .bus_err_in       (s[3]),
        .mcheck_in        (s[4]),
        .addr_dbe_in      (s[5]),
        .data_dbe_in      (s[6]),
        .l2_dbe_in        (s[7]),
        .ext_irq_in       (s[8]),
        .smgmt_irq_in     (s[9]),
        .thermal_hot_in   (s[10]),
        .pmon_limit_in    (s[11]),
        .pmon_int_en_in   (s[12]),
        .dec_value_in     (dec),
        .instr_done_in    (s[13]),
        .instr_is_sync_in (s[14]),
        .branch_done_in   (s[15]),
        .iabr_hit_in      (s[16]),
        .sync_fault_in    (s[22:17]),
        .msr_ee_in        (s[23]),
        .msr_me_in        (s[24]),
        .msr_se_in        (s[25]),
        .msr_be_in        (s[26]),
        .msr_ip_in        (s[27]),
        .exc_take_out     (take),
        .exc_vector_out   (vec),
        .checkstop_out    (cs)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input int rq, input logic et, input logic ec, input logic [31:0] ev);
        n_chk++;
        if (take !== et || cs !== ec || vec !== ev) begin
            n_fail++;
            $display("FAIL R%0d: take=%0b cs=%0b vec=%h expected take=%0b cs=%0b vec=%h",
                     rq, take, cs, vec, et, ec, ev);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        s   = '0;
        dec = '0;
        rst = 1'b1;
        repeat (3) tick();
        chk(1, 1'b0, 1'b0, 32'h0);              // R1 during reset
        rst = 1'b0;
        tick();
        chk(1, 1'b0, 1'b0, 32'h0);              // R1 after reset

        for (int i = 0; i < NROWS; i++) begin
            s = TBL[i].stim;
            tick();
            chk(int'(TBL[i].rq), TBL[i].take, TBL[i].cs, TBL[i].vec);
            s = '0;
            tick();
        end

        // R6: rise of bit 31 with EE set is taken once; the held level does not retrigger
        s = S_EE; dec = 32'h8000_0000;
        tick();
        chk(6, 1'b1, 1'b0, 32'h900);
        tick(); tick();
        chk(6, 1'b0, 1'b0, 32'h0);
        dec = 32'h0; tick(); tick();

        // R6: rise while EE clear stays pending until EE is set
        s = '0; dec = 32'h8000_1234;
        tick();
        chk(6, 1'b0, 1'b0, 32'h0);
        tick(); tick();
        chk(6, 1'b0, 1'b0, 32'h0);
        s = S_EE;
        tick();
        chk(6, 1'b1, 1'b0, 32'h900);
        s = '0; dec = 32'h0; tick(); tick();

        // R6/R9/R10: external and decrementer rise together; dec kept pending past holdoff
        s = S_EXT | S_EE; dec = 32'h8000_0000;
        tick();
        chk(9, 1'b1, 1'b0, 32'h500);
        s = S_EE;
        tick();
        chk(10, 1'b0, 1'b0, 32'h0);
        tick();
        chk(6, 1'b1, 1'b0, 32'h900);
        s = '0; dec = 32'h0; tick(); tick();

        // R10: a held request alternates take and holdoff
        s = S_EXT | S_EE;
        tick();
        chk(10, 1'b1, 1'b0, 32'h500);
        tick();
        chk(10, 1'b0, 1'b0, 32'h0);
        tick();
        chk(10, 1'b1, 1'b0, 32'h500);
        s = '0; tick(); tick();

        // R4/R3: reset pin overrides a disabled machine check
        s = S_MCP | S_HARD;
        tick();
        chk(4, 1'b1, 1'b0, 32'h100);
        s = '0; tick(); tick();

        // R1: reset clears a pending decrementer and ignores an MSB already set
        dec = 32'h8000_0000;
        tick();
        rst = 1'b1;
        tick();
        chk(1, 1'b0, 1'b0, 32'h0);
        rst = 1'b0;
        s = S_EE;
        tick();
        chk(1, 1'b0, 1'b0, 32'h0);
        tick();
        chk(6, 1'b0, 1'b0, 32'h0);
        s = '0; dec = 32'h0; tick();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule